// File: doc/BRIEF.md
# Opcode-Steered Byte Store

This block is a 256-by-8 synchronous memory that sits behind the parallel side of a serial slave. It accepts one 10-bit command word per clock when a valid strobe is high. The top two bits of the word select an action, and the lower eight bits carry either an address or a data byte.

Two private address registers hold state between commands. One points at the location the next write will fill. The other points at the location the next readback will fetch. A host sets a write pointer and then stores a byte there. Separately, it sets a read pointer and then asks for a readback. The fetched byte appears on an 8-bit output, together with a one-cycle valid pulse. Serial shifting and chip-select handling live outside this block.

Top module: `cmd_ram`

## Requirements
- R1: While `rstN` is low at a clock edge, both address registers, `rdData` and `rdValid` are cleared to zero, and no command is acted on. After reset, a readback or a write with no pointer loaded uses location 0.
- R2: The command word `cmdWord[9:8]` is the opcode and `cmdWord[7:0]` is the payload.
- R3: Opcode 2'b00 loads the payload into the write pointer and leaves every memory location unchanged.
- R4: Opcode 2'b01 stores the payload into the location named by the write pointer.
- R5: Opcode 2'b10 loads the payload into the read pointer.
- R6: Opcode 2'b11 drives the byte at the read pointer onto `rdData` and raises `rdValid` for exactly one cycle, starting one clock after the command is accepted. In every other cycle `rdValid` is low and `rdData` keeps its last value.
- R7: When `cmdValid` is low, the command word has no effect on memory, on either pointer or on the outputs.
- R8: The two pointers are independent, so loading one leaves the other unchanged.
- R9: The payload bits of an opcode 2'b11 command are ignored.
- R10: A readback issued in the cycle right after a write to the same location returns the newly written byte.
- R11: Reset does not clear memory contents.
- R12: The write pointer does not advance after a write, so repeated writes land on the same location and the last one wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| cmdValid | input | 1 | Command word qualifier |
| cmdWord | input | 10 | Opcode in bits 9:8, payload in bits 7:0 |
| rdData | output | 8 | Readback byte |
| rdValid | output | 1 | One-cycle pulse marking a fresh readback |

## Verification
Neither pointer can be seen directly, so a corrupted pointer only shows up on `rdData`. A wrong read pointer shows up in the cycle after the next readback command. A wrong write pointer or a lost write stays hidden until that location is read back. The bench therefore loads every location with a distinct pattern and issues many readbacks, including one that follows a write directly. This keeps the gap between a fault and its visible effect to a few cycles.

// File: rtl/cmd_ram_pkg.sv
package cmd_ram_pkg;

  typedef enum logic [1:0] {
    OP_SET_WPTR = 2'b00,
    OP_STORE    = 2'b01,
    OP_SET_RPTR = 2'b10,
    OP_FETCH    = 2'b11
  } opcode_e;

  typedef struct packed {
    logic loadWrPtr;
    logic storeByte;
    logic loadRdPtr;
    logic fetchByte;
  } strobes_t;

endpackage

// File: rtl/cmd_ram_ctrl.sv
module cmd_ram_ctrl
  import cmd_ram_pkg::*;
#(
  parameter int PAYLOAD_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [PAYLOAD_W+1:0] cmdWord,
  output strobes_t             strobes,
  output logic [PAYLOAD_W-1:0] payload
);

  localparam int OP_LSB = PAYLOAD_W;

  opcode_e opcode;

  assign opcode  = opcode_e'(cmdWord[OP_LSB +: 2]);
  assign payload = cmdWord[PAYLOAD_W-1:0];

  always_comb begin
    strobes = '0;
    if (cmdValid && rstN) begin
      unique case (opcode)
        OP_SET_WPTR: strobes.loadWrPtr = 1'b1;
        OP_STORE:    strobes.storeByte = 1'b1;
        OP_SET_RPTR: strobes.loadRdPtr = 1'b1;
        OP_FETCH:    strobes.fetchByte = 1'b1;
        default:     strobes = '0;
      endcase
    end
  end

  // R7: a fetch strobe one cycle ago implies a valid fetch word was presented then
  assert_fetch_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(strobes.fetchByte) |-> $past(cmdValid) && $past(cmdWord[OP_LSB +: 2]) == 2'b11);

endmodule

// File: rtl/cmd_ram_dpath.sv
module cmd_ram_dpath
  import cmd_ram_pkg::*;
#(
  parameter int PAYLOAD_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             strobes,
  input  logic [PAYLOAD_W-1:0] payload,
  output logic [PAYLOAD_W-1:0] rdData,
  output logic                 rdValid
);

  localparam int DEPTH = 1 << PAYLOAD_W;

  logic [PAYLOAD_W-1:0] wrPtr;
  logic [PAYLOAD_W-1:0] rdPtr;
  logic [PAYLOAD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.loadWrPtr) wrPtr <= payload;
      if (strobes.loadRdPtr) rdPtr <= payload;
    end
  end

  always_ff @(posedge clk) begin
    if (rstN && strobes.storeByte) store[wrPtr] <= payload;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobes.fetchByte;
      if (strobes.fetchByte) rdData <= store[rdPtr];
    end
  end

  assert_pulse_origin_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rstN) && $past(strobes.fetchByte));

  assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !rdValid |-> $stable(rdData));

  assert_wptr_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !$past(strobes.loadWrPtr) |-> $stable(wrPtr));

  assert_rptr_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !$past(strobes.loadRdPtr) |-> $stable(rdPtr));

  assert_store_lands_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.storeByte |=> store[$past(wrPtr)] == $past(payload));

endmodule

// File: rtl/cmd_ram.sv
module cmd_ram
  import cmd_ram_pkg::*;
#(
  parameter int PAYLOAD_W = 8,
  localparam int CMD_W    = PAYLOAD_W + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [CMD_W-1:0]     cmdWord,
  output logic [PAYLOAD_W-1:0] rdData,
  output logic                 rdValid
);

  strobes_t             strobes;
  logic [PAYLOAD_W-1:0] payload;

  cmd_ram_ctrl #(.PAYLOAD_W(PAYLOAD_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdWord  (cmdWord),
    .strobes  (strobes),
    .payload  (payload)
  );

  cmd_ram_dpath #(.PAYLOAD_W(PAYLOAD_W)) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .payload (payload),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

  // R1: a cycle of reset leaves the readback port quiet
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !$past(rstN) && $past(rstN, 2) == 1'b0 && rstN |-> !rdValid && rdData == '0);

endmodule

// File: tb/tb_cmd_ram.sv
module tb_cmd_ram;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [9:0] cmdWord = '0;
  logic [7:0] rdData;
  logic       rdValid;

  always #2ns clk = ~clk;

  cmd_ram dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .rdData(rdData), .rdValid(rdValid)
  );

  int checks = 0;
  int errors = 0;

  // behavioural model
  int   mMem [256];
  bit   mKnown [256];
  int   mWr = 0;
  int   mRd = 0;
  bit   expValid = 0;
  int   expData = 0;
  bit   expKnown = 1;
  string lastTag = "R1";

  function automatic int pattern(int a);
    return (a * 37 + 11) & 255;
  endfunction

  task automatic compare();
    checks++;
    if (rdValid !== expValid) begin
      errors++;
      $display("FAIL %s rdValid got %0b exp %0b", lastTag, rdValid, expValid);
    end
    if (expKnown) begin
      checks++;
      if (rdData !== expData[7:0]) begin
        errors++;
        $display("FAIL %s rdData got %02h exp %02h", lastTag, rdData, expData[7:0]);
      end
    end
  endtask

  task automatic step(input bit v, input bit [1:0] op, input bit [7:0] pl, input string tag);
    @(negedge clk);
    compare();
    cmdValid = v;
    cmdWord  = {op, pl};
    lastTag  = tag;
    expValid = 0;
    if (v) begin
      case (op)
        2'b00: mWr = pl;
        2'b01: begin mMem[mWr] = pl; mKnown[mWr] = 1; end
        2'b10: mRd = pl;
        default: begin
          expValid = 1;
          expData  = mMem[mRd];
          expKnown = mKnown[mRd];
        end
      endcase
    end
  endtask

  task automatic doReset(input string tag);
    @(negedge clk);
    compare();
    rstN = 1'b0;
    cmdValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    lastTag = tag;
    expValid = 0; expData = 0; expKnown = 1;
    mWr = 0; mRd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got running exp finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mMem[i] = 0; mKnown[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    doReset("R1");
    step(0, 2'b00, 8'h00, "R1");
    // R3, R4, R2 fill every location
    for (int i = 0; i < 256; i++) begin
      step(1, 2'b00, i[7:0], "R3");
      step(1, 2'b01, pattern(i), "R4");
    end
    step(0, 2'b00, 8'h00, "R4");
    // R11 memory kept, R1 pointers zero, R9 payload ignored
    doReset("R1");
    step(1, 2'b11, 8'h5A, "R11");
    step(0, 2'b00, 8'h00, "R9");
    // R5, R6 readbacks of assorted locations, back-to-back too
    for (int a = 0; a < 256; a += 23) begin
      step(1, 2'b10, a[7:0], "R5");
      step(1, 2'b11, 8'hFF, "R6");
      step(1, 2'b11, 8'h00, "R6");
      step(0, 2'b11, 8'h00, "R6");
    end
    // R7 ignored commands
    step(1, 2'b00, 8'h30, "R7");
    step(0, 2'b01, 8'hEE, "R7");
    step(0, 2'b00, 8'h31, "R7");
    step(0, 2'b10, 8'h30, "R7");
    step(1, 2'b10, 8'h30, "R7");
    step(1, 2'b11, 8'h00, "R7");
    step(1, 2'b10, 8'h31, "R7");
    step(1, 2'b11, 8'h00, "R7");
    step(1, 2'b01, 8'h99, "R7");
    step(1, 2'b10, 8'h30, "R7");
    step(1, 2'b11, 8'h00, "R7");
    // R8 independent pointers
    step(1, 2'b10, 8'h20, "R8");
    step(1, 2'b00, 8'h10, "R8");
    step(1, 2'b01, 8'h77, "R8");
    step(1, 2'b11, 8'h00, "R8");
    step(1, 2'b10, 8'h10, "R8");
    step(1, 2'b11, 8'h00, "R8");
    // R10 read immediately after write
    step(1, 2'b10, 8'h40, "R10");
    step(1, 2'b00, 8'h40, "R10");
    step(1, 2'b01, 8'hC3, "R10");
    step(1, 2'b11, 8'h00, "R10");
    step(1, 2'b01, 8'h3C, "R10");
    step(1, 2'b11, 8'h00, "R10");
    // R3 pointer load alone changes no memory
    step(1, 2'b00, 8'h55, "R3");
    step(1, 2'b10, 8'h55, "R3");
    step(1, 2'b11, 8'h00, "R3");
    // R12 repeated writes hit the same location
    step(1, 2'b00, 8'h66, "R12");
    step(1, 2'b01, 8'h01, "R12");
    step(1, 2'b01, 8'h02, "R12");
    step(1, 2'b10, 8'h67, "R12");
    step(1, 2'b11, 8'h00, "R12");
    step(1, 2'b10, 8'h66, "R12");
    step(1, 2'b11, 8'h00, "R12");
    step(0, 2'b00, 8'h00, "R12");
    step(0, 2'b00, 8'h00, "R6");
    @(negedge clk);
    compare();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule